// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address of every beat of a four-beat memory burst. On an enabled clock edge with the step control low, it captures a new starting address. On an enabled edge with the step control high, it moves to the next beat. Only the two lowest address bits take part in the sequence. All higher bits keep the value that was captured.

A static mode input selects the beat order. The interleaved order combines the start address with the beat count by XOR. The linear order counts upward modulo four and wraps within the aligned group of four. An active-low clock enable freezes the block: while it is high, edges are ignored. The output feeds the read and write address paths of a synchronous SRAM controller. It is valid in the same cycle that follows the capturing or stepping edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first enabled edge, `addr_out` is all zeros.
- R2: On a rising edge with `clk_en_n` low and `step` low, the block captures `addr_in`. `addr_out` equals that address until the next enabled edge.
- R3: On a rising edge with `clk_en_n` low and `step` high, bits `ADDR_W-1` down to 2 of `addr_out` keep the captured value.
- R4: With `ilv_mode` high (interleaved order), beats 0 to 3 have low bits equal to the start low bits XOR 0, 1, 2 and 3.
- R5: With `ilv_mode` low (linear order), each step adds one modulo 4 to the low two bits. For example, a start of 2 gives 2, 3, 0, 1.
- R6: Steps after the fourth beat continue in the same group of four. The fifth beat equals the start address in both orders.
- R7: A rising edge with `clk_en_n` high changes nothing: neither a new `addr_in` nor `step` has any effect on `addr_out`.
- R8: A capture in the middle of a burst restarts the sequence at beat 0 of the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the state |
| step | input | 1 | 0 captures `addr_in`, 1 advances to the next beat |
| ilv_mode | input | 1 | Static order select: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W | External starting address |
| addr_out | output | ADDR_W | Address of the current beat |

## Verification
Every result is due straight after the rising edge that captures or advances the state. No further register lies between that edge and `addr_out`, so the result never waits a second cycle.

The driver changes the inputs one time unit after a falling edge. For each cycle it queues the address the requirements predict. The monitor removes one entry a quarter period after each rising edge and compares it with `addr_out`. Each comparison therefore falls in the cycle in which that result is valid, well away from any edge.

Stall cycles queue the value held from before the stall. This proves at the port that neither a changed `addr_in` nor `step` had any effect.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              step,
  input  logic              ilv_mode,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int BEAT_W = 2;

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_ilv, low_lin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (!clk_en_n) begin
      if (!step) begin
        base_q <= addr_in;
        beat_q <= '0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign low_ilv  = base_q[BEAT_W-1:0] ^ beat_q;
  assign low_lin  = base_q[BEAT_W-1:0] + beat_q;
  assign addr_out = {base_q[ADDR_W-1:BEAT_W], ilv_mode ? low_ilv : low_lin};
endmodule

module burst_addr_seq_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              step,
  input logic              ilv_mode,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out
);
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !step) |=> (addr_out == $past(addr_in)));

  assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && step) |=> (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));

  assert_ilv_bit0_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && step && ilv_mode) |=>
      (!ilv_mode || (addr_out[0] != $past(addr_out[0]))));

  assert_linear_increment_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && step && !ilv_mode) |=>
      (ilv_mode || (addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1))));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ((addr_out == $past(addr_out)) || (ilv_mode != $past(ilv_mode))));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en_n = 1'b1;
  logic step = 1'b0;
  logic ilv_mode = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] exp_q[$];
  string tag_q[$];

  logic [AW-1:0] m_start;
  logic [1:0] m_beat;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .step(step),
    .ilv_mode(ilv_mode), .addr_in(addr_in), .addr_out(addr_out)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] lo;
    if (ilv_mode) lo = m_start[1:0] ^ m_beat;
    else          lo = 2'(m_start[1:0] + m_beat);
    return {m_start[AW-1:2], lo};
  endfunction

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic en_n, input logic stp, input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    #1;
    clk_en_n = en_n;
    step = stp;
    addr_in = a;
    if (!en_n) begin
      if (!stp) begin
        m_start = a;
        m_beat = 2'd0;
      end else begin
        m_beat = m_beat + 2'd1;
      end
    end
    exp_q.push_back(model_addr());
    tag_q.push_back(tag);
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    #1;
    ilv_mode = m;
    clk_en_n = 1'b1;
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      automatic logic [AW-1:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(addr_out, e, t);
    end
  end

  initial begin
    m_start = '0;
    m_beat = 2'd0;
    repeat (3) @(posedge clk);
    #2;
    check(addr_out, '0, "R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check(addr_out, '0, "R1 after release");

    ilv_mode = 1'b1;
    drive(1'b0, 1'b0, 21'h1ABCD6, "R2 capture interleaved");
    drive(1'b0, 1'b1, 21'h000000, "R4 R3 beat1");
    drive(1'b0, 1'b1, 21'h1FFFFF, "R4 R3 beat2");
    drive(1'b0, 1'b1, 21'h000000, "R4 R3 beat3");
    drive(1'b0, 1'b1, 21'h000000, "R6 interleaved wrap");
    drive(1'b0, 1'b1, 21'h000000, "R6 interleaved beat5");
    drive(1'b0, 1'b0, 21'h0F0F01, "R2 capture start1");
    drive(1'b0, 1'b1, 21'h000000, "R4 start1 beat1");
    drive(1'b1, 1'b1, 21'h000000, "R7 stall with step");
    drive(1'b1, 1'b0, 21'h155555, "R7 stall with new address");
    drive(1'b0, 1'b1, 21'h000000, "R4 start1 beat2 after stall");
    drive(1'b0, 1'b1, 21'h000000, "R4 start1 beat3");
    drive(1'b0, 1'b1, 21'h000000, "R6 wrap start1");

    set_mode(1'b0);
    drive(1'b0, 1'b0, 21'h0A5A52, "R2 capture linear");
    drive(1'b0, 1'b1, 21'h1FFFFF, "R5 R3 beat1");
    drive(1'b0, 1'b1, 21'h000000, "R5 beat2 wraps low bits");
    drive(1'b0, 1'b1, 21'h000000, "R5 beat3");
    drive(1'b0, 1'b1, 21'h000000, "R6 linear wrap");
    drive(1'b0, 1'b1, 21'h000000, "R6 linear beat5");
    drive(1'b0, 1'b0, 21'h100003, "R8 capture mid burst");
    drive(1'b0, 1'b1, 21'h000000, "R5 start3 beat1");
    drive(1'b1, 1'b0, 21'h0000FF, "R7 linear stall");
    drive(1'b0, 1'b1, 21'h000000, "R5 start3 beat2");
    drive(1'b0, 1'b0, 21'h03C3C1, "R8 restart linear");
    drive(1'b0, 1'b1, 21'h000000, "R8 first step after restart");
    drive(1'b1, 1'b1, 21'h000000, "R7 trailing idle");
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (2000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule